// File: doc/BRIEF.md
# Bridge Address Window Mask Decoder

This block sits in a host-to-PCI bridge and decides which host addresses the bridge claims. It holds one 32-bit window mask with two granularities. The low sixteen bits each enable a 16 MB window inside the top 256 MB page, 0xF0000000 to 0xFFFFFFFF. Bits 16 to 30 each enable a 256 MB region elsewhere in the address map. Bit 31 has no region.

The mask is read and written through a configuration register port, in the configuration space the bridge owns at byte offsets 64 and above. The register holds the bus value with its byte order reversed.

A 2-bit bridge index strap sets two things. It sets the reset value of the mask, which opens the bridge's own 32 MB region. It also sets the base address of the bridge's control window. For each host address the block reports whether it is claimed and which mask bit claimed it.

Top module: `bridge_window_decoder`

## Requirements
- R1: While rst_ni is low, the mask resets to 3 shifted left by twice bridge_idx_i. A read of offset 0x48 after reset returns this value byte-reversed; for index 2 the read returns 0x30000000.
- R2: A write to byte offset 0x48 stores the byte-reversed cfg_wdata_i. A read of offset 0x48 returns the stored mask byte-reversed again, so it gives back the value that was written.
- R3: When host_addr_i[31:28] is 0xF and mask bit n is set, with n equal to host_addr_i[27:24], hit_o is 1.
- R4: When host_addr_i[31:28] is k, with k from 0 to 14, and mask bit 16+k is set, hit_o is 1.
- R5: Mask bit 31 is stored and reads back, but it never causes a hit. An address in the 0xF page whose fine bit is clear gives hit_o 0.
- R6: When hit_o is 1, match_idx_o is the lowest mask bit index whose region contains the address. When hit_o is 0, match_idx_o is 0.
- R7: A mask write changes the address decoding only from the cycle after the clock edge that takes the write.
- R8: At offsets of 64 and above other than 0x48, reads return 0, writes leave the mask unchanged, and cfg_own_o is 1.
- R9: At offsets below 64, cfg_own_o is 0, reads return 0, and writes leave the mask unchanged.
- R10: ctrl_base_o equals 0xF0000000 plus bridge_idx_i shifted left by 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bridge_idx_i | input | 2 | Bridge index strap |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset |
| cfg_wdata_i | input | 32 | Configuration write data, bus byte order |
| cfg_rdata_o | output | 32 | Configuration read data, combinational from cfg_addr_i |
| cfg_own_o | output | 1 | Offset lies in the range this block serves (64 and above) |
| host_addr_i | input | 32 | Host address to decode |
| hit_o | output | 1 | Address is claimed by an enabled window |
| match_idx_o | output | 5 | Mask bit that matched; 0 when there is no hit |
| ctrl_base_o | output | 32 | Base address of the bridge control window |

## Verification
A mask bit that is stored wrongly appears at the ports in two ways. Reads of offset 0x48 return it immediately, and the decoder misjudges hit_o for every address in that bit's region from the next cycle on. A missing byte reversal leaves the readback correct but opens the wrong windows. For that reason the stimulus pairs each random mask write with address probes that are checked against a mask model. A write that lands on the wrong offset, or one that takes effect too early, shows up on the first probe of the affected region.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W   = 32;
  localparam int MASK_W   = 32;
  localparam int CFG_AW   = 8;
  localparam int FINE_N   = 16;
  localparam int COARSE_N = 15;
  localparam int IDX_W    = $clog2(MASK_W);
  localparam int PAGE_W   = 4;
  localparam int FSEL_W   = $clog2(FINE_N);
  localparam logic [PAGE_W-1:0] FINE_PAGE = 4'hF;
  localparam logic [ADDR_W-1:0] CTRL_ROOT = 32'hF000_0000;
  localparam int CTRL_SHIFT = 25;

  function automatic logic [31:0] bswap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/bwd_mask_reg.sv
module bwd_mask_reg
  import bwd_pkg::*;
#(
  parameter logic [CFG_AW-1:0] MASK_OFFS = 8'h48,
  parameter logic [CFG_AW-1:0] OWN_BASE  = 8'd64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bridge_idx_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              cfg_own_o,
  output logic [MASK_W-1:0] mask_o
);
  logic [MASK_W-1:0] mask_q;
  logic              sel_mask;

  assign cfg_own_o = cfg_addr_i >= OWN_BASE;
  assign sel_mask  = cfg_own_o && (cfg_addr_i == MASK_OFFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 mask_q <= MASK_W'(3) << {bridge_idx_i, 1'b0};
    else if (cfg_wr_i && sel_mask) mask_q <= bswap32(cfg_wdata_i);
  end

  assign cfg_rdata_o = sel_mask ? bswap32(mask_q) : '0;
  assign mask_o      = mask_q;

  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && cfg_addr_i == MASK_OFFS) |=> (mask_q == bswap32($past(cfg_wdata_i)))); // R2
  AST_OTHER_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && cfg_addr_i != MASK_OFFS) |=> $stable(mask_q)); // R8
  AST_LOW_OFFS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i < OWN_BASE) |-> (cfg_rdata_o == '0 && !cfg_own_o)); // R9
endmodule

// File: rtl/bwd_region_match.sv
module bwd_region_match
  import bwd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MASK_W-1:0] region_o
);
  logic [PAGE_W-1:0] page;
  logic [FSEL_W-1:0] fsel;

  assign page = addr_i[ADDR_W-1 -: PAGE_W];
  assign fsel = addr_i[ADDR_W-PAGE_W-1 -: FSEL_W];

  for (genvar n = 0; n < FINE_N; n++) begin : g_fine
    assign region_o[n] = (page == FINE_PAGE) && (fsel == FSEL_W'(n));
  end
  for (genvar k = 0; k < COARSE_N; k++) begin : g_coarse
    assign region_o[FINE_N+k] = (page == PAGE_W'(k));
  end
  for (genvar u = FINE_N + COARSE_N; u < MASK_W; u++) begin : g_spare
    assign region_o[u] = 1'b0;  // no region behind these bits
  end
endmodule

// File: rtl/bwd_lowest_idx.sv
module bwd_lowest_idx #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        bridge_idx_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              cfg_own_o,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  match_idx_o,
  output logic [ADDR_W-1:0] ctrl_base_o
);
  logic [MASK_W-1:0] mask;
  logic [MASK_W-1:0] region;

  bwd_mask_reg u_mask (
    .clk_i, .rst_ni, .bridge_idx_i, .cfg_wr_i, .cfg_addr_i, .cfg_wdata_i,
    .cfg_rdata_o, .cfg_own_o, .mask_o(mask)
  );

  bwd_region_match u_region (.addr_i(host_addr_i), .region_o(region));

  bwd_lowest_idx #(.W(MASK_W), .IDX_W(IDX_W)) u_prio (
    .vec_i(mask & region), .any_o(hit_o), .idx_o(match_idx_o)
  );

  assign ctrl_base_o = CTRL_ROOT + (ADDR_W'(bridge_idx_i) << CTRL_SHIFT);

  AST_HIT_HAS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> mask[match_idx_o]); // R6
  AST_IDLE_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (match_idx_o == '0)); // R6
  AST_NO_SPARE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_idx_o != IDX_W'(MASK_W - 1))); // R5
  AST_CTRL_BASE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_base_o[CTRL_SHIFT-1:0] == '0) && (ctrl_base_o[31:27] == 5'b11110)); // R10
endmodule

// File: tb/bridge_window_decoder_test.sv
`timescale 1ns/1ps
module bridge_window_decoder_test;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [1:0]  bridge_idx_i = 2'd2;
  logic        cfg_wr_i = 0;
  logic [7:0]  cfg_addr_i = 8'h48;
  logic [31:0] cfg_wdata_i = 0;
  logic [31:0] cfg_rdata_o;
  logic        cfg_own_o;
  logic [31:0] host_addr_i = 0;
  logic        hit_o;
  logic [4:0]  match_idx_o;
  logic [31:0] ctrl_base_o;

  int checks = 0, fails = 0;
  logic [31:0] model;

  always #4 clk_i = ~clk_i;

  bridge_window_decoder uut (.*);

  function automatic logic [31:0] rev(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [5:0] exp_dec(input logic [31:0] m, input logic [31:0] a);
    int b;
    b = (a[31:28] == 4'hF) ? int'(a[27:24]) : 16 + int'(a[31:28]);
    if (b != 31 && m[b]) return {1'b1, 5'(b)};
    return 6'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic probe(input string req, input logic [31:0] a);
    logic [5:0] e;
    host_addr_i = a; #1;
    e = exp_dec(model, a);
    chk(req, {26'd0, hit_o, match_idx_o}, {26'd0, e});
  endtask

  task automatic rd(input string req, input logic [7:0] off, input logic [31:0] exp);
    cfg_addr_i = off; #1;
    chk(req, cfg_rdata_o, exp);
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk_i);
    cfg_wr_i = 1; cfg_addr_i = off; cfg_wdata_i = d;
    @(posedge clk_i); #1;
    cfg_wr_i = 0;
    if (off == 8'h48) model = rev(d);
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    // R1 / R10 reset with index 2
    #20; rst_ni = 1; model = 32'h30;
    @(negedge clk_i);
    rd("R1", 8'h48, 32'h3000_0000);
    chk("R10", ctrl_base_o, 32'hF400_0000);
    probe("R3", 32'hF412_3456);
    probe("R3", 32'hF5FF_FFFF);
    probe("R5", 32'hF300_0000);
    probe("R6", 32'h1000_0000);
    // R2 byte reversal: bus 0x00000180 -> mask 0x80010000 (bit 16 coarse 0, bit 31)
    wr(8'h48, 32'h0000_0180);
    rd("R2", 8'h48, 32'h0000_0180);
    probe("R4", 32'h0ABC_DEF0);
    probe("R5", 32'hFF00_0000);
    probe("R5", 32'hF400_0000);
    // R7: pending write not yet visible
    @(negedge clk_i);
    cfg_wr_i = 1; cfg_addr_i = 8'h48; cfg_wdata_i = rev(32'h0000_0400);
    host_addr_i = 32'hFA00_0000; #1;
    chk("R7", {31'd0, hit_o}, 32'd0);
    @(posedge clk_i); #1; cfg_wr_i = 0; model = 32'h0000_0400;
    probe("R7", 32'hFA00_0000);
    // R6 lowest index with coarse and fine
    wr(8'h48, rev(32'h7FFF_FFFF));
    probe("R6", 32'hF000_0000);
    probe("R6", 32'hE000_0000);
    // R8 other owned offsets
    wr(8'h4C, 32'hFFFF_FFFF);
    rd("R8", 8'h4C, 32'h0);
    rd("R8", 8'h48, rev(32'h7FFF_FFFF));
    chk("R8", {31'd0, cfg_own_o}, 32'd0 | 32'(8'h48 >= 64));
    cfg_addr_i = 8'h80; #1; chk("R8", {31'd0, cfg_own_o}, 32'd1);
    // R9 low offsets
    wr(8'h10, 32'h1234_5678);
    cfg_addr_i = 8'h10; #1;
    chk("R9", {31'd0, cfg_own_o}, 32'd0);
    chk("R9", cfg_rdata_o, 32'd0);
    rd("R9", 8'h48, rev(32'h7FFF_FFFF));
    // random
    for (int i = 0; i < 300; i++) begin
      wr(($urandom % 4 == 0) ? 8'(64 + 4 * ($urandom % 8)) : 8'h48, $urandom);
      rd("R2", 8'h48, rev(model));
      for (int j = 0; j < 6; j++) begin
        logic [31:0] a;
        a = $urandom;
        if (j < 3) a[31:28] = 4'hF;
        probe(a[31:28] == 4'hF ? "R3" : "R4", a);
      end
    end
    // R1 / R10 with index 3
    @(negedge clk_i); bridge_idx_i = 2'd3; rst_ni = 0; #10; rst_ni = 1; model = 32'hC0;
    rd("R1", 8'h48, 32'hC000_0000);
    chk("R10", ctrl_base_o, 32'hF600_0000);
    probe("R3", 32'hF700_0010);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule